// File: doc/BRIEF.md
# Graphics Controller Extension Lock Gate

This block sits on the index/data register port of a VGA-compatible graphics controller. It routes each access by index. The low indices go to the standard register set, which lies outside the block. A window of vendor extension slots above them is kept in a small register file. The top index holds a lock/status register.

The extension window is closed unless a three-bit key field in the lock/status register holds one particular value. While the window is closed, reads of it return all ones and writes to it are dropped. The lock/status register itself can always be read and written.

When the lock/status register is read, the lock field is combined with five configuration strap bits. These straps are captured from the memory-data pins while reset is held.

Top module: `gcx_lock_gate`

## Requirements
- R1: While reset is asserted, the lock field clears to 3'b000, so the window starts closed, and every extension slot clears to 0x00.
- R2: A write to index 0xF stores wr_data[2:0] as the lock field. wr_data[7:3] is not stored. A read of index 0xF returns the lock field in bits 2:0.
- R3: The extension window is open only while the lock field equals 3'b101. Any other value closes it.
- R4: While the window is closed, a read of any index from 0x9 to 0xE returns 0xFF.
- R5: While the window is closed, writes to indices 0x9–0xE are dropped, and the stored slot values stay unchanged when the window is opened again.
- R6: While the window is open, each of the six slots at indices 0x9–0xE stores its own written byte and returns it on read.
- R7: On every rising clock edge with rst_n low, strap[4:0] is captured. A read of index 0xF returns the captured straps in bits 7:3, with strap[4] in bit 7 and strap[0] in bit 3. Strap changes after reset has been released have no effect.
- R8: For indices 0x0–0x8, the access goes to the standard port whatever the lock state: std_wr_en and std_rd_en follow the strobes, std_idx and std_wr_data follow the inputs, and the read result is std_rd_data. For other indices, both standard strobes stay low.
- R9: rd_data is registered. It takes the value of a read one clock after rd_en is sampled high, and it holds that value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| idx | input | 4 | Register index of the current access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read result |
| strap | input | 5 | Configuration strap bits from the memory-data pins |
| std_wr_en | output | 1 | Write strobe to the standard register set |
| std_rd_en | output | 1 | Read strobe to the standard register set |
| std_idx | output | 4 | Index to the standard register set |
| std_wr_data | output | 8 | Write data to the standard register set |
| std_rd_data | input | 8 | Combinational read data from the standard register set |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that std_rd_data is valid in the cycle its read strobe is high.

The stimulus drives every input on the falling clock edge, so nothing changes at a sampling edge. Each strobe is raised for exactly one cycle and is never overlapped with the other. A combinational model of the standard set, whose data depends on the index, answers the standard port. Straps are changed only after reset has been released, which checks that the captured values are frozen.

// File: rtl/gcx_pkg.sv
// Package: shared index map, field widths and the access-target type for the
// graphics-controller extension lock gate. Assumes a 16-entry index space.
package gcx_pkg;
    localparam int          GCX_IDX_W   = 4;
    localparam int          GCX_DATA_W  = 8;
    localparam int          GCX_KEY_W   = 3;
    localparam int          GCX_STRAP_W = 5;
    localparam logic [3:0]  GCX_EXT_LO  = 4'h9;
    localparam logic [3:0]  GCX_EXT_HI  = 4'hE;
    localparam logic [3:0]  GCX_LOCK_IX = 4'hF;
    localparam logic [2:0]  GCX_KEY     = 3'b101;

    typedef enum logic [1:0] {
        TGT_STD  = 2'd0,
        TGT_EXT  = 2'd1,
        TGT_LOCK = 2'd2
    } gcx_tgt_e;
endpackage

// File: rtl/gcx_lock_ctl.sv
// Lock controller: holds the key field and the strap bits that were captured
// during reset. The window is open only while the key field matches KEY.
// Assumes a synchronous active-low reset that is held for at least one edge.
module gcx_lock_ctl #(
    parameter int         KEY_W   = 3,
    parameter int         STRAP_W = 5,
    parameter logic [2:0] KEY     = 3'b101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_we,
    input  logic [KEY_W-1:0]   key_wdata,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [KEY_W-1:0]   key_q,
    output logic [STRAP_W-1:0] strap_q,
    output logic               unlocked
);
    // Key field: cleared by reset and replaced on each lock-register write.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (key_we) key_q <= key_wdata;
    end

    // Strap capture: the pins are sampled only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_in;
    end

    // Window state: compare the stored field with the key.
    always_comb unlocked = (key_q == KEY[KEY_W-1:0]);

    // R1: reset leaves the window closed
    a_r1_reset_locked: assert property (@(posedge clk)
        !rst_n |=> !unlocked);
    // R3: writing the key opens the window
    a_r3_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && key_wdata == KEY[KEY_W-1:0]) |=> unlocked);
    // R3: writing any other value closes it
    a_r3_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && key_wdata != KEY[KEY_W-1:0]) |=> !unlocked);
    // R7: captured straps are frozen once reset is released
    a_r7_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(strap_q));
endmodule

// File: rtl/gcx_ext_regs.sv
// Extension register file: one byte-wide register per slot in the extension
// window. A write lands only if the window is open. Assumes slot < N_SLOT
// whenever we is high.
module gcx_ext_regs #(
    parameter int DATA_W = 8,
    parameter int N_SLOT = 6,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              unlocked,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [N_SLOT*DATA_W-1:0] file_q;

    genvar g;
    generate
        for (g = 0; g < N_SLOT; g++) begin : g_slot
            // Slot g: cleared by reset, written on an open-window hit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    file_q[g*DATA_W +: DATA_W] <= '0;
                else if (we && unlocked && slot == SLOT_W'(g))
                    file_q[g*DATA_W +: DATA_W] <= wdata;
            end
        end
    endgenerate

    // Read select: pick the addressed slot.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_SLOT; i++)
            if (slot == SLOT_W'(i)) rdata = file_q[i*DATA_W +: DATA_W];
    end

    // R5: a write while the window is closed changes nothing
    a_r5_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !unlocked) |=> $stable(file_q));
    // R1: reset clears every slot
    a_r1_file_cleared: assert property (@(posedge clk)
        !rst_n |=> file_q == '0);
endmodule

// File: rtl/gcx_rd_path.sv
// Read path: registers the result of a read strobe. A closed window reads as
// all ones. Assumes the sources are valid in the cycle the strobe is high.
module gcx_rd_path
    import gcx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  gcx_tgt_e          tgt,
    input  logic              unlocked,
    input  logic [DATA_W-1:0] std_data,
    input  logic [DATA_W-1:0] ext_data,
    input  logic [DATA_W-1:0] lock_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sel;

    // Source select by target, with the closed-window mask.
    always_comb begin
        unique case (tgt)
            TGT_EXT:  sel = unlocked ? ext_data : '1;
            TGT_LOCK: sel = lock_data;
            default:  sel = std_data;
        endcase
    end

    // Result register: loads on a read strobe, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

    // R4: a closed-window read returns all ones
    a_r4_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && tgt == TGT_EXT && !unlocked) |=> rd_data == '1);
    // R9: without a strobe the result holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/gcx_lock_gate.sv
// Top: decodes the index into the standard, extension or lock target, routes
// the strobes, and puts the lock controller, extension file and read path
// together. Assumes wr_en and rd_en are never high in the same cycle.
module gcx_lock_gate
    import gcx_pkg::*;
#(
    parameter int         IDX_W   = GCX_IDX_W,
    parameter int         DATA_W  = GCX_DATA_W,
    parameter int         KEY_W   = GCX_KEY_W,
    parameter int         STRAP_W = GCX_STRAP_W,
    parameter logic [3:0] EXT_LO  = GCX_EXT_LO,
    parameter logic [3:0] EXT_HI  = GCX_EXT_HI,
    parameter logic [3:0] LOCK_IX = GCX_LOCK_IX,
    parameter logic [2:0] KEY     = GCX_KEY
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [STRAP_W-1:0] strap,
    output logic               std_wr_en,
    output logic               std_rd_en,
    output logic [IDX_W-1:0]   std_idx,
    output logic [DATA_W-1:0]  std_wr_data,
    input  logic [DATA_W-1:0]  std_rd_data
);
    localparam int N_SLOT = int'(EXT_HI) - int'(EXT_LO) + 1;
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

    gcx_tgt_e           tgt;
    logic [SLOT_W-1:0]  slot;
    logic               ext_we, key_we, unlocked;
    logic [KEY_W-1:0]   key_q;
    logic [STRAP_W-1:0] strap_q;
    logic [DATA_W-1:0]  ext_rdata, lock_rdata;
    logic [IDX_W-1:0]   slot_full;

    // Index decode: pick the target for the current index.
    always_comb begin
        if (idx == IDX_W'(LOCK_IX))
            tgt = TGT_LOCK;
        else if (idx >= IDX_W'(EXT_LO) && idx <= IDX_W'(EXT_HI))
            tgt = TGT_EXT;
        else
            tgt = TGT_STD;
    end

    // Strobe routing: each write goes to exactly one target.
    always_comb begin
        slot_full   = idx - IDX_W'(EXT_LO);
        slot        = slot_full[SLOT_W-1:0];
        ext_we      = wr_en && (tgt == TGT_EXT);
        key_we      = wr_en && (tgt == TGT_LOCK);
        std_wr_en   = wr_en && (tgt == TGT_STD);
        std_rd_en   = rd_en && (tgt == TGT_STD);
        std_idx     = idx;
        std_wr_data = wr_data;
        lock_rdata  = {strap_q, key_q};
    end

    gcx_lock_ctl #(
        .KEY_W   (KEY_W),
        .STRAP_W (STRAP_W),
        .KEY     (KEY)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_we    (key_we),
        .key_wdata (wr_data[KEY_W-1:0]),
        .strap_in  (strap),
        .key_q     (key_q),
        .strap_q   (strap_q),
        .unlocked  (unlocked)
    );

    gcx_ext_regs #(
        .DATA_W (DATA_W),
        .N_SLOT (N_SLOT)
    ) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ext_we),
        .unlocked (unlocked),
        .slot     (slot),
        .wdata    (wr_data),
        .rdata    (ext_rdata)
    );

    gcx_rd_path #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .tgt       (tgt),
        .unlocked  (unlocked),
        .std_data  (std_rd_data),
        .ext_data  (ext_rdata),
        .lock_data (lock_rdata),
        .rd_data   (rd_data)
    );

    // R8: a write strobe reaches at most one target
    a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({std_wr_en, ext_we, key_we}));
    // R8: lock and extension writes never reach the standard port
    a_r8_std_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_we || key_we) |-> !std_wr_en);
    // R2: the lock read carries the stored field in its low bits
    a_r2_key_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && tgt == TGT_LOCK) |=> rd_data[KEY_W-1:0] == key_q);
endmodule

// File: tb/sim_gcx_lock_gate.sv
// Bench for gcx_lock_gate: a vector table walk, then directed tests for
// the strobes, hold, strap capture and a second reset.
module sim_gcx_lock_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] idx = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [4:0] strap = 5'b10110;
    logic       std_wr_en, std_rd_en;
    logic [3:0] std_idx;
    logic [7:0] std_wr_data, std_rd_data;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    // Standard-set model: data depends on the index.
    assign std_rd_data = 8'hA0 | {4'h0, std_idx};

    gcx_lock_gate u0 (
        .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .strap(strap),
        .std_wr_en(std_wr_en), .std_rd_en(std_rd_en), .std_idx(std_idx),
        .std_wr_data(std_wr_data), .std_rd_data(std_rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [7:0] d);
        @(negedge clk); idx = i; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] i, output logic [7:0] v);
        @(negedge clk); idx = i; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
    endtask

    // Vector: {is_read, idx, data, expected, req number}
    localparam int NV = 24;
    localparam logic [24:0] VEC [0:NV-1] = '{
        {1'b1, 4'hF, 8'h00, 8'hB0, 4'd7}, // R7 R1 straps 10110, closed
        {1'b1, 4'h9, 8'h00, 8'hFF, 4'd4}, // R4 closed read
        {1'b1, 4'hE, 8'h00, 8'hFF, 4'd4},
        {1'b0, 4'hA, 8'h5A, 8'h00, 4'd5}, // R5 dropped write
        {1'b0, 4'hF, 8'hFD, 8'h00, 4'd2}, // R2 key 101, upper bits ignored
        {1'b1, 4'hF, 8'h00, 8'hB5, 4'd2},
        {1'b1, 4'hA, 8'h00, 8'h00, 4'd5}, // R5 nothing landed
        {1'b1, 4'h9, 8'h00, 8'h00, 4'd1}, // R1 slots cleared
        {1'b0, 4'hA, 8'h5A, 8'h00, 4'd6}, // R6 open writes
        {1'b0, 4'hE, 8'hC3, 8'h00, 4'd6},
        {1'b0, 4'h9, 8'h17, 8'h00, 4'd6},
        {1'b1, 4'hA, 8'h00, 8'h5A, 4'd6},
        {1'b1, 4'hE, 8'h00, 8'hC3, 4'd6},
        {1'b1, 4'h9, 8'h00, 8'h17, 4'd6},
        {1'b0, 4'hF, 8'h04, 8'h00, 4'd3}, // R3 100 closes
        {1'b1, 4'hE, 8'h00, 8'hFF, 4'd3},
        {1'b1, 4'hF, 8'h00, 8'hB4, 4'd2},
        {1'b0, 4'hE, 8'h11, 8'h00, 4'd5}, // R5 dropped while closed
        {1'b1, 4'h3, 8'h00, 8'hA3, 4'd8}, // R8 standard read while closed
        {1'b0, 4'hF, 8'h07, 8'h00, 4'd3}, // R3 111 is not the key
        {1'b1, 4'hA, 8'h00, 8'hFF, 4'd3},
        {1'b0, 4'hF, 8'h0D, 8'h00, 4'd3}, // R3 101 reopens
        {1'b1, 4'hE, 8'h00, 8'hC3, 4'd5}, // R5 old value kept
        {1'b1, 4'h8, 8'h00, 8'hA8, 4'd8}  // R8 standard read while open
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap = 5'b01001;              // R7 change after reset: ignored
        check("R9 reset rd_data", rd_data, 8'h00);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][24]) begin
                rd(VEC[k][23:20], v);
                check($sformatf("R%0d vec %0d", VEC[k][3:0], k), v, VEC[k][11:4]);
            end else begin
                wr(VEC[k][23:20], VEC[k][19:12]);
            end
        end

        // R8 write strobe routing
        @(negedge clk); idx = 4'h5; wr_data = 8'h3C; wr_en = 1'b1; #1;
        check("R8 std_wr_en on 0x5", {7'd0, std_wr_en}, 8'h01);
        check("R8 std_wr_data", std_wr_data, 8'h3C);
        check("R8 std_idx", {4'd0, std_idx}, 8'h05);
        @(negedge clk); idx = 4'hB; #1;
        check("R8 std_wr_en low on 0xB", {7'd0, std_wr_en}, 8'h00);
        @(negedge clk); wr_en = 1'b0; idx = 4'h2; rd_en = 1'b1; #1;
        check("R8 std_rd_en on 0x2", {7'd0, std_rd_en}, 8'h01);
        @(negedge clk); rd_en = 1'b0;
        check("R8 std read value", rd_data, 8'hA2);

        // R9 hold while no strobe
        idx = 4'hF;
        repeat (2) @(negedge clk);
        check("R9 hold", rd_data, 8'hA2);
        rd(4'hB, v);
        check("R6 slot 0xB written via routing test", v, 8'h3C);

        // R1 and R7: a second reset with new straps
        @(negedge clk); rst_n = 1'b0; strap = 5'b01001;
        repeat (2) @(negedge clk); rst_n = 1'b1; strap = 5'b11111;
        rd(4'hF, v);
        check("R7 new straps, R1 closed", v, 8'h48);
        rd(4'hA, v);
        check("R1 closed after reset", v, 8'hFF);
        wr(4'hF, 8'h05);
        rd(4'hE, v);
        check("R1 slot cleared by reset", v, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule